// File: doc/BRIEF.md
# Periodic Refresh Request Timer

This block paces auto-refresh for a DRAM controller. A down-counter measures the longest allowed gap between refreshes, derived from the clock frequency (a build parameter in MHz). The rule is that 8192 rows must each be refreshed within 64 ms. Each time the counter runs out, the block adds the refreshes now due to an owed-refresh total and raises a request to the controller.

Two pacing modes are available. In single mode each interval lasts `(64000 * CLK_MHZ) / 8192` cycles and adds one refresh. In burst mode the interval is eight times longer and adds eight refreshes, which the controller issues back to back. The controller answers with an acknowledge once it has performed every refresh shown on the count. The timer reloads when a request is issued, not when it is acknowledged, so a slow controller does not lower the average refresh rate. Intervals that expire before the acknowledge accumulate on the count instead of being lost.

Top module: `rfsh_req_timer`

## Requirements
- R1: After reset, `req` is 0 and `req_count` is 0.
- R2: In single mode (`burst_mode` = 0) with `enable` held high, an interval expires every P = (64000 * CLK_MHZ) / 8192 clock cycles and adds 1 to `req_count`. The first expiry comes P cycles after `enable` is first sampled high.
- R3: In burst mode (`burst_mode` = 1), an interval lasts 8 * P cycles and adds 8 to `req_count`.
- R4: While `enable` is low, no interval expires and `req_count` changes only through `ack`. When `enable` rises, a full interval starts.
- R5: `req` is high exactly when `req_count` is nonzero, and it stays high until acknowledged.
- R6: An expiry that occurs before an acknowledge adds to the existing count. It is never dropped.
- R7: `ack` clears `req_count` to 0 on the next edge. If an expiry falls on the same edge, only that expiry's refreshes remain.
- R8: The interval reloads at expiry. The time from one expiry to the next does not depend on when `ack` arrives.
- R9: `req_count` saturates at 2^CNT_W - 1 and never wraps.
- R10: `burst_mode` is taken at each reload. A change in mid-interval does not alter the running interval or the amount it adds.
- R11: `ack` while `req_count` is 0 has no effect on the count or on interval timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Refresh generation enable |
| burst_mode | input | 1 | 1 selects burst pacing (8 per request), 0 selects single |
| ack | input | 1 | Controller has performed all owed refreshes |
| req | output | 1 | Refresh request, high while refreshes are owed |
| req_count | output | CNT_W | Number of refreshes owed |

## Verification
The bench leaves several intervals unacknowledged to show they stack. A design that overwrote or dropped the pending request would show a count of 1 instead of 3. It acknowledges late and measures the gap between request edges: reloading on acknowledge would stretch that gap past P. It places an acknowledge on the exact cycle of an expiry, where a wrong priority yields either 0 or the old count plus one. It switches to burst pacing in mid-interval and runs long enough without acknowledge to reach saturation. A wrapping count would fall to a small value, and an early mode switch would give a short interval or a wrong increment.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  localparam int unsigned WINDOW_US = 64000;
  localparam int unsigned ROW_COUNT = 8192;
  localparam int unsigned BURST_LEN = 8;

  // Single-refresh spacing in cycles for a given clock frequency
  function automatic int unsigned base_period(input int unsigned mhz);
    return (WINDOW_US * mhz) / ROW_COUNT;
  endfunction

  // Interval length for the selected pacing mode
  function automatic int unsigned interval_cycles(input int unsigned mhz, input logic burst);
    return burst ? base_period(mhz) * BURST_LEN : base_period(mhz);
  endfunction

  // Refreshes owed per expiry
  function automatic int unsigned refreshes_per_req(input logic burst);
    return burst ? BURST_LEN : 1;
  endfunction
endpackage

// File: rtl/rfsh_interval_cnt.sv
module rfsh_interval_cnt
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic burst_mode,
  output logic tick,
  output logic tick_burst
);
  localparam int unsigned LOAD_SINGLE = interval_cycles(CLK_MHZ, 1'b0) - 1;
  localparam int unsigned LOAD_BURST  = interval_cycles(CLK_MHZ, 1'b1) - 1;
  localparam int unsigned TMR_W       = $clog2(LOAD_BURST + 1);

  logic [TMR_W-1:0] cnt;
  logic [TMR_W-1:0] load_val;
  logic             mode_q;

  assign load_val   = burst_mode ? TMR_W'(LOAD_BURST) : TMR_W'(LOAD_SINGLE);
  assign tick       = enable && (cnt == '0);
  assign tick_burst = mode_q;

  // Reload on expiry (not on acknowledge) and continuously while disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= TMR_W'(LOAD_SINGLE);
      mode_q <= 1'b0;
    end else if (!enable || tick) begin
      cnt    <= load_val;
      mode_q <= burst_mode;
    end else begin
      cnt    <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rfsh_owed_acc.sv
module rfsh_owed_acc
  import rfsh_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             tick_burst,
  input  logic             ack,
  output logic [CNT_W-1:0] owed
);
  localparam logic [CNT_W:0] SAT = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0] kept;
  logic [CNT_W:0] added;
  logic [CNT_W:0] sum;

  assign kept  = ack ? '0 : {1'b0, owed};
  assign added = tick ? (CNT_W+1)'(refreshes_per_req(tick_burst)) : '0;
  assign sum   = kept + added;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          owed <= '0;
    else if (sum > SAT)  owed <= SAT[CNT_W-1:0];
    else                 owed <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/rfsh_req_timer.sv
module rfsh_req_timer #(
  parameter int unsigned CLK_MHZ = 400,
  parameter int unsigned CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             burst_mode,
  input  logic             ack,
  output logic             req,
  output logic [CNT_W-1:0] req_count
);
  logic tick;
  logic tick_burst;

  rfsh_interval_cnt #(.CLK_MHZ(CLK_MHZ)) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .burst_mode (burst_mode),
    .tick       (tick),
    .tick_burst (tick_burst)
  );

  rfsh_owed_acc #(.CNT_W(CNT_W)) u_owed (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .tick_burst (tick_burst),
    .ack        (ack),
    .owed       (req_count)
  );

  assign req = |req_count;
endmodule

// File: rtl/rfsh_req_timer_chk.sv
module rfsh_req_timer_chk
  import rfsh_pkg::*;
#(
  parameter int unsigned CLK_MHZ = 400,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             ack,
  input logic             req,
  input logic [CNT_W-1:0] req_count,
  input logic             tick,
  input logic             tick_burst
);
  localparam int unsigned P_MIN = base_period(CLK_MHZ);

  int unsigned gap;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap <= 0;
    else if (!enable || tick)    gap <= 0;
    else if (gap < P_MIN)        gap <= gap + 1;
  end

  p_min_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap + 1 >= P_MIN));
  p_idle_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable && !ack |=> $stable(req_count));
  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);
  p_pending_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ack && !tick |=> $stable(req_count));
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !tick |=> req_count == '0);
  p_ack_tick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack && tick && !tick_burst |=> req_count == CNT_W'(1));
  p_ack_tick_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack && tick && tick_burst |=> req_count == CNT_W'(BURST_LEN));
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ack && req |=> req_count >= $past(req_count));
endmodule

bind rfsh_req_timer rfsh_req_timer_chk #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rfsh_req_timer_test.sv
`timescale 1ns/1ps
module rfsh_req_timer_test;
  localparam int MHZ = 16;
  localparam int CW  = 8;
  localparam int P   = (64000 * MHZ) / 8192;   // 125
  localparam int PB  = P * 8;                  // 1000
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, enable = 0, burst_mode = 0, ack = 0;
  logic req;
  logic [CW-1:0] req_count;

  int checks = 0, fails = 0, cyc = 0;
  int m_owed = 0, m_due = 0;
  bit m_mode = 0;
  string phase = "R1";

  rfsh_req_timer #(.CLK_MHZ(MHZ), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .burst_mode(burst_mode),
    .ack(ack), .req(req), .req_count(req_count));

  always #10 clk = ~clk;

  // Behavioural reference: owed total and absolute due cycle
  always @(posedge clk) begin
    int nxt;
    cyc++;
    if (rst_n) begin
      nxt = ack ? 0 : m_owed;
      if (enable && m_due == cyc) begin
        nxt += m_mode ? 8 : 1;
        if (nxt > MAXC) nxt = MAXC;
      end
      if (!enable || m_due == cyc) begin
        m_due  = cyc + (burst_mode ? PB : P);
        m_mode = burst_mode;
      end
      m_owed = nxt;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (req !== (m_owed != 0) || req_count !== CW'(m_owed)) begin
        fails++;
        $display("FAIL %s model: req=%0b count=%0d expected req=%0b count=%0d",
                 phase, req, req_count, m_owed != 0, m_owed);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic wait_req();
    while (!req) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    check("R1 req", req, 0);
    check("R1 count", req_count, 0);
    rst_n = 1;

    phase = "R4";
    repeat (400) @(negedge clk);
    check("R4 disabled count", req_count, 0);

    phase = "R2";
    enable = 1;
    repeat (124) @(negedge clk);
    check("R2 not early", req, 0);
    @(negedge clk);
    check("R2 first expiry", req_count, 1);

    phase = "R6";
    repeat (250) @(negedge clk);
    check("R6 stacked", req_count, 3);

    phase = "R7";
    pulse_ack();
    check("R7 cleared", req_count, 0);

    phase = "R11";
    pulse_ack();
    check("R11 ack at zero", req_count, 0);

    phase = "R8";
    wait_req(); t0 = cyc;
    repeat (60) @(negedge clk);
    pulse_ack();
    wait_req();
    check("R8 spacing after late ack", cyc - t0, P);

    phase = "R7";
    while (m_due != cyc + 1) @(negedge clk);
    pulse_ack();
    check("R7 ack on expiry", req_count, 1);

    phase = "R10";
    pulse_ack();
    burst_mode = 1;
    wait_req();
    check("R10 running interval kept", req_count, 1);
    t0 = cyc;
    pulse_ack();
    wait_req();
    phase = "R3";
    check("R3 burst spacing", cyc - t0, PB);
    check("R3 burst amount", req_count, 8);

    phase = "R9";
    repeat (35 * PB) @(negedge clk);
    check("R9 saturated", req_count, MAXC);

    phase = "R4";
    pulse_ack();
    enable = 0;
    repeat (3000) @(negedge clk);
    check("R4 no expiry when off", req_count, 0);
    burst_mode = 0;
    @(negedge clk);
    enable = 1;
    repeat (124) @(negedge clk);
    check("R4 full interval on restart", req_count, 0);
    @(negedge clk);
    check("R4 restart expiry", req_count, 1);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule